// File: doc/BRIEF.md
# Link-Layer Connection Event Timer

This block paces the connection events of a low-energy radio link in either the central (initiating) or the peripheral (responding) role. A free-running anchor counter, advanced by a one-microsecond tick, marks the start of every event. From there the block decides, packet by packet, whether the local side sends next, listens next, or closes the event. It works from strobes the radio gives it: the end of the local transmission, and a received packet with its CRC verdict and the peer's more-data flag.

The block never touches packet contents. It only asks the radio to start a transmission, opens and closes the receive window, and marks the end of each event with a pulse. The connection interval, the longest allowed event, and the receive timeout are inputs counted in ticks, so firmware can change them between events.

Top module: `conn_event_ctrl`

## Requirements
- R1: An anchor point occurs on the first tick after reset and then every `interval_us` ticks. An event is always finished before the next anchor point.
- R2: At an anchor point the central role pulses `tx_start` in the following clock cycle. The peripheral role instead raises `listen_en` in that cycle.
- R3: When an exchange continues after a received packet, `tx_start` pulses exactly 150 ticks after the clock cycle in which `rx_done` was sampled.
- R4: In the central role, a good packet whose peer more-data flag is clear closes the event in the next cycle if `local_more` is also low. If either flag is set, the event continues per R3.
- R5: In the peripheral role, `tx_done` closes the event in the next cycle when the last received packet was good and both its peer more-data flag and `local_more` are clear. Otherwise `listen_en` rises in the next cycle.
- R6: After `listen_en` rises, if `rx_done` does not arrive within `rx_timeout_us` ticks, the event closes in either role.
- R7: A second bad-CRC packet in a row closes the event. The count of bad packets is cleared by any good packet and at every anchor point.
- R8: An event is cut off `min(max_len_us, interval_us - 150)` ticks after its anchor point, whatever state it is in.
- R9: `evt_closed` is a one-cycle pulse. `tx_start` and `listen_en` stay low between events.
- R10: `tx_start` and `listen_en` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-microsecond timing strobe |
| role_central | input | 1 | 1 = central role, 0 = peripheral role |
| interval_us | input | TW | Connection interval in ticks |
| max_len_us | input | TW | Longest allowed event in ticks |
| rx_timeout_us | input | TW | Receive window length in ticks |
| local_more | input | 1 | Local side has more data queued |
| tx_done | input | 1 | Strobe: local transmission finished |
| rx_done | input | 1 | Strobe: a packet was received |
| rx_crc_ok | input | 1 | CRC verdict for the packet flagged by `rx_done` |
| rx_peer_more | input | 1 | Peer more-data flag of the received packet |
| tx_start | output | 1 | One-cycle request to begin a transmission |
| listen_en | output | 1 | Receive window open |
| evt_closed | output | 1 | One-cycle pulse when an event ends |

## Verification
Both roles are run through four kinds of event.

- In the plain exchange both more-data flags are clear. It separates a correct close from a needless extra packet.
- In the continued exchanges, more data is flagged first by the peer and then by the local side. Each flag must keep the event alive on its own, and the 150-tick spacing is checked.
- In one event a good packet falls between two bad ones, and in another two bad packets come back to back. This shows the bad-CRC count is cleared by a good packet and closes only on a true second failure in a row.
- In a silent event no packet arrives, and in an over-long event the exchange runs past its budget. These tell the receive timeout apart from the event-length cutoff, since the two would close the event in different cycles.

// File: rtl/conn_event_ctrl.sv
module conn_event_ctrl #(
  parameter int TW     = 16,
  parameter int IFS_US = 150
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_us,
  input  logic          role_central,
  input  logic [TW-1:0] interval_us,
  input  logic [TW-1:0] max_len_us,
  input  logic [TW-1:0] rx_timeout_us,
  input  logic          local_more,
  input  logic          tx_done,
  input  logic          rx_done,
  input  logic          rx_crc_ok,
  input  logic          rx_peer_more,
  output logic          tx_start,
  output logic          listen_en,
  output logic          evt_closed
);

  localparam int GW = $clog2(IFS_US);
  localparam logic [TW-1:0] ONE = TW'(1);
  localparam logic [TW-1:0] IFS_T = TW'(IFS_US);

  typedef enum logic [1:0] {S_IDLE, S_TX, S_GAP, S_RX} state_t;

  state_t        state;
  logic [TW-1:0] anc, elapsed, tmo;
  logic [GW-1:0] gap;
  logic          bad_q, good_q, pmore_q;

  logic [TW-1:0] budget, lim;
  logic          anchor, active, over;

  assign budget    = interval_us - IFS_T;
  assign lim       = (max_len_us < budget) ? max_len_us : budget;
  assign anchor    = tick_us && (anc == '0);
  assign active    = (state != S_IDLE);
  assign over      = active && tick_us && ((elapsed + ONE) >= lim);
  assign listen_en = (state == S_RX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      anc        <= '0;
      elapsed    <= '0;
      tmo        <= '0;
      gap        <= '0;
      bad_q      <= 1'b0;
      good_q     <= 1'b0;
      pmore_q    <= 1'b0;
      tx_start   <= 1'b0;
      evt_closed <= 1'b0;
    end else begin
      tx_start   <= 1'b0;
      evt_closed <= 1'b0;
      if (tick_us) anc <= anchor ? interval_us - ONE : anc - ONE;
      if (active && tick_us) elapsed <= elapsed + ONE;
      case (state)
        S_IDLE: if (anchor) begin
          elapsed <= '0;
          bad_q   <= 1'b0;
          good_q  <= 1'b0;
          pmore_q <= 1'b0;
          if (role_central) begin
            tx_start <= 1'b1;
            state    <= S_TX;
          end else begin
            tmo   <= rx_timeout_us;
            state <= S_RX;
          end
        end
        S_TX: if (tx_done) begin
          if (!role_central && good_q && !local_more && !pmore_q) begin
            evt_closed <= 1'b1;
            state      <= S_IDLE;
          end else begin
            tmo   <= rx_timeout_us;
            state <= S_RX;
          end
        end
        S_RX: if (rx_done) begin
          bad_q  <= !rx_crc_ok;
          good_q <= rx_crc_ok;
          if (rx_crc_ok) pmore_q <= rx_peer_more;
          if ((!rx_crc_ok && bad_q) ||
              (role_central && rx_crc_ok && !local_more && !rx_peer_more)) begin
            evt_closed <= 1'b1;
            state      <= S_IDLE;
          end else begin
            gap   <= GW'(IFS_US - 1);
            state <= S_GAP;
          end
        end else if (tick_us) begin
          if (tmo <= ONE) begin
            evt_closed <= 1'b1;
            state      <= S_IDLE;
          end else begin
            tmo <= tmo - ONE;
          end
        end
        S_GAP: if (tick_us) begin
          if (gap == '0) begin
            tx_start <= 1'b1;
            state    <= S_TX;
          end else begin
            gap <= gap - 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
      if (over) begin
        tx_start   <= 1'b0;
        evt_closed <= 1'b1;
        state      <= S_IDLE;
      end
    end
  end

  p_no_overlap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    anchor |-> state == S_IDLE);

  p_central_tx_r2: assert property (@(posedge clk) disable iff (!rst_n)
    anchor && role_central |=> tx_start);

  p_periph_listen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    anchor && !role_central |=> listen_en);

  p_two_bad_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RX) && rx_done && !rx_crc_ok && bad_q |=> evt_closed);

  p_close_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_closed |=> !evt_closed);

  p_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_start && listen_en));

endmodule

// File: tb/conn_event_ctrl_tb.sv
module conn_event_ctrl_tb;
  localparam int TW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_us = 1'b1;
  logic role_central = 1'b1;
  logic [TW-1:0] interval_us = 16'd1000;
  logic [TW-1:0] max_len_us = 16'd900;
  logic [TW-1:0] rx_timeout_us = 16'd40;
  logic local_more = 1'b0;
  logic tx_done = 1'b0;
  logic rx_done = 1'b0;
  logic rx_crc_ok = 1'b0;
  logic rx_peer_more = 1'b0;
  logic tx_start, listen_en, evt_closed;

  int cyc = 0;
  int checks = 0;
  int errors = 0;

  typedef struct { int kind; int at; string req; } exp_t;
  exp_t q[$];

  conn_event_ctrl #(.TW(TW), .IFS_US(150)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .role_central(role_central),
    .interval_us(interval_us), .max_len_us(max_len_us), .rx_timeout_us(rx_timeout_us),
    .local_more(local_more), .tx_done(tx_done), .rx_done(rx_done),
    .rx_crc_ok(rx_crc_ok), .rx_peer_more(rx_peer_more),
    .tx_start(tx_start), .listen_en(listen_en), .evt_closed(evt_closed));

  always #5 clk = ~clk;

  always @(posedge clk) if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  task automatic expect_evt(int kind, int at, string req);
    exp_t e;
    e.kind = kind; e.at = at; e.req = req;
    q.push_back(e);
  endtask

  task automatic seen(int kind);
    exp_t e;
    checks++;
    if (q.size() == 0) begin
      errors++;
      $display("FAIL R9 unexpected kind %0d at cycle %0d, expected nothing", kind, cyc);
    end else begin
      e = q.pop_front();
      if (e.kind != kind || e.at != cyc) begin
        errors++;
        $display("FAIL %s kind %0d at cycle %0d, expected kind %0d at cycle %0d",
                 e.req, kind, cyc, e.kind, e.at);
      end
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (tx_start) seen(0);
    if (evt_closed) seen(1);
  end

  task automatic chk(logic act, logic exp, string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: got %0b expected %0b", req, cyc, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic send_tx_done();
    tx_done = 1'b1;
    @(negedge clk);
    tx_done = 1'b0;
  endtask

  task automatic send_rx(logic ok, logic more);
    rx_done = 1'b1; rx_crc_ok = ok; rx_peer_more = more;
    @(negedge clk);
    rx_done = 1'b0; rx_crc_ok = 1'b0; rx_peer_more = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(tx_start, 1'b0, "R9 reset tx_start");
    chk(listen_en, 1'b0, "R9 reset listen_en");
    chk(evt_closed, 1'b0, "R9 reset evt_closed");
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired at cycle %0d, expected completion", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // Central role
    role_central = 1'b1;
    @(negedge clk);
    expect_evt(0, 1, "R2 central anchor tx");
    do_reset();
    wait_cyc(6);  send_tx_done();
    chk(listen_en, 1'b1, "R5 listen after own tx");
    wait_cyc(20); expect_evt(1, 21, "R4 close when no more data"); send_rx(1'b1, 1'b0);
    wait_cyc(22); chk(listen_en, 1'b0, "R9 idle after close");
    chk(tx_start, 1'b0, "R9 idle no tx");

    expect_evt(0, 1001, "R1 second anchor");
    wait_cyc(1005); send_tx_done();
    wait_cyc(1010); expect_evt(0, 1161, "R3 gap after peer more"); send_rx(1'b1, 1'b1);
    wait_cyc(1170); send_tx_done();
    wait_cyc(1180); expect_evt(0, 1331, "R7 first bad continues"); send_rx(1'b0, 1'b0);
    wait_cyc(1340); send_tx_done();
    wait_cyc(1350); expect_evt(1, 1351, "R7 second bad closes"); send_rx(1'b0, 1'b0);

    expect_evt(0, 2001, "R1 third anchor");
    wait_cyc(2005); send_tx_done();
    expect_evt(1, 2046, "R6 central receive timeout");

    wait_cyc(2100);
    local_more = 1'b1;
    expect_evt(0, 3001, "R1 fourth anchor");
    wait_cyc(3005); send_tx_done();
    wait_cyc(3010); expect_evt(0, 3161, "R4 local more continues"); send_rx(1'b1, 1'b0);
    wait_cyc(3170); send_tx_done();
    wait_cyc(3180); expect_evt(0, 3331, "R7 bad after anchor clear"); send_rx(1'b0, 1'b0);
    wait_cyc(3340); send_tx_done();
    wait_cyc(3350); expect_evt(0, 3501, "R7 good clears bad count"); send_rx(1'b1, 1'b0);
    wait_cyc(3510); send_tx_done();
    wait_cyc(3520); expect_evt(0, 3671, "R7 single bad after good"); send_rx(1'b0, 1'b0);
    wait_cyc(3680); send_tx_done();
    wait_cyc(3690); expect_evt(0, 3841, "R3 gap late in event"); send_rx(1'b1, 1'b0);
    wait_cyc(3845); send_tx_done();
    expect_evt(1, 3851, "R8 interval guard cutoff");
    wait_cyc(3860);
    local_more = 1'b0;
    chk(listen_en, 1'b0, "R8 window closed by cutoff");

    // Peripheral role
    role_central = 1'b0;
    do_reset();
    wait_cyc(1); chk(listen_en, 1'b1, "R2 peripheral listens at anchor");
    chk(tx_start, 1'b0, "R2 peripheral no tx at anchor");
    wait_cyc(10); expect_evt(0, 161, "R3 peripheral reply gap"); send_rx(1'b1, 1'b0);
    wait_cyc(170); expect_evt(1, 171, "R5 peripheral closes after reply"); send_tx_done();

    wait_cyc(1010); expect_evt(0, 1161, "R3 peripheral reply gap"); send_rx(1'b1, 1'b1);
    wait_cyc(1170); send_tx_done();
    chk(listen_en, 1'b1, "R5 peer more keeps listening");
    wait_cyc(1180); expect_evt(0, 1331, "R7 peripheral replies to bad"); send_rx(1'b0, 1'b0);
    wait_cyc(1340); send_tx_done();
    chk(listen_en, 1'b1, "R5 listen after bad packet");
    wait_cyc(1350); expect_evt(1, 1351, "R7 peripheral two bad close"); send_rx(1'b0, 1'b0);

    expect_evt(1, 2041, "R6 peripheral receive timeout");
    wait_cyc(2100);
    max_len_us = 16'd300;
    wait_cyc(3010); expect_evt(0, 3161, "R3 peripheral reply gap"); send_rx(1'b1, 1'b1);
    wait_cyc(3170); send_tx_done();
    wait_cyc(3180); send_rx(1'b1, 1'b1);
    expect_evt(1, 3301, "R8 max length cutoff");
    wait_cyc(3320);
    chk(tx_start, 1'b0, "R8 no tx after cutoff");
    chk(listen_en, 1'b0, "R9 idle after cutoff");

    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R1 %0d expected outputs missing, expected 0", q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule